// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host 24 general-purpose I/O lines arranged as three 8-bit ports, called A, B and C. The host reaches the block over an 8-bit data path. It selects one of four locations with a two-bit address. Each access is qualified by an active-low select plus active-low read and write strobes. Every line is modelled as three separate signals: a pin input, a driven value and an output enable.

The lines form two independently configured groups of twelve. Group A is port A together with the upper half of port C. Group B is port B together with the lower half of port C. A group can run in any of these ways:

- As plain I/O, with a direction set separately for each port and each C nibble.
- As a strobed handshake channel, where three port C lines turn into strobe, buffer-flag and interrupt signals.
- For group A only, as a bidirectional bus with five handshake lines. One of these is the interrupt line borrowed from the lower C nibble.

A control word written to the fourth location does one of two things. It either redefines the modes and directions, or it sets or clears a single port C bit without touching the others.

Top module: `pario_ctrl`

## Requirements
- R1: After reset every output enable is low, every output latch is zero, and all ports read as basic-mode inputs. The reset control word is the parameter RESET_CTRL, default 8'h9B.
- R2: Addresses map as 0 = port A, 1 = port B, 2 = port C, 3 = control; control reads return 8'h00. A write acts once, at the first rising clock edge where the select and the write strobe are both low. With the select high, the strobes have no effect.
- R3: A control write with bit 7 = 1 redefines the configuration and clears all output latches and handshake flags. Its fields are:
  - bits 6:5: group A mode (00 basic, 01 strobed, 1x bidirectional)
  - bit 4: port A input
  - bit 3: upper C input
  - bit 2: group B strobed
  - bit 1: port B input
  - bit 0: lower C input
- R4: In basic mode a port or C nibble whose direction bit is 1 is an input, with enables low, and reads return its pins. With the direction bit at 0 the enables are high, the latch drives the lines, and reads return the latch.
- R5: A control write with bit 7 = 0 loads port C latch bit number wdata[3:1] with wdata[0] and leaves the other seven bits unchanged.
- R6: Strobed input: a falling edge on the strobe line latches the port pins and sets the input-full flag. The strobe is C4 for port A and C2 for port B; the flag appears on C5 for A and on C1 for B. A host read of the port returns the latched byte and clears the flag.
- R7: Interrupts appear on C3 for group A and on C0 for group B. They are enabled by port C latch bits:
  - C4: port A input
  - C6: port A output
  - C2: port B
  An input interrupt equals input-full AND its enable.
- R8: Strobed output: a host write to the port drives the active-low output-full line low (C7 for A, C1 for B) and clears the group's pending output interrupt. A falling edge on the acknowledge line (C6 for A, C2 for B) returns the line high and raises the output interrupt when it is enabled.
- R9: Bidirectional mode: port A lines are driven only while C6 is low. C4 strobes input data, C5 shows input-full, C7 shows output-full (low), and C3 carries the OR of both interrupt conditions.
- R10: Port C reads return, for each bit: the driven value for handshake outputs; the enable latch bit for handshake inputs; and the basic-mode rule from R4 for the remaining bits.
- R11: host_rdata_oe is high exactly while select and read are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Active-low select |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_addr | input | 2 | Location select |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data to host |
| host_rdata_oe | output | 1 | Read data drive enable |
| line_a_in | input | 8 | Port A pin values |
| line_a_out | output | 8 | Port A driven values |
| line_a_oe | output | 8 | Port A output enables |
| line_b_in | input | 8 | Port B pin values |
| line_b_out | output | 8 | Port B driven values |
| line_b_oe | output | 8 | Port B output enables |
| line_c_in | input | 8 | Port C pin values |
| line_c_out | output | 8 | Port C driven values |
| line_c_oe | output | 8 | Port C output enables |

## Verification
The bench builds the controller with the default RESET_CTRL of 8'h9B, so the block leaves reset with every line an input in basic mode. This default makes the reset-state checks meaningful, and every other configuration is reached only through control writes. A vector table walks four basic-mode direction mixes. Directed sequences then cover strobed input on group A, strobed output on group B and the bidirectional mode with its ack-gated drive. They also check single-bit writes, select gating and the latch clearing done by a mode write.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NCH    = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  localparam logic [ADDR_W-1:0] LOC_A   = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_B   = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_C   = 2'd2;
  localparam logic [ADDR_W-1:0] LOC_CTL = 2'd3;

  // port C roles in handshake modes
  localparam int C_IRQ_B = 0;
  localparam int C_FLG_B = 1;
  localparam int C_HS_B  = 2;
  localparam int C_IRQ_A = 3;
  localparam int C_STB_A = 4;
  localparam int C_IBF_A = 5;
  localparam int C_ACK_A = 6;
  localparam int C_OBF_A = 7;

  typedef enum logic [1:0] {GM_BASIC = 2'd0, GM_STROBED = 2'd1, GM_BIDIR = 2'd2} gmode_e;

  typedef struct packed {
    gmode_e a_mode;
    logic   a_in;
    logic   cu_in;
    logic   b_strobed;
    logic   b_in;
    logic   cl_in;
  } cfg_t;

  typedef struct packed {
    logic [DATA_W-1:0] drv;
    logic [DATA_W-1:0] sense;
  } crole_t;

  function automatic cfg_t decode_mode(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.a_mode    = w[6] ? GM_BIDIR : (w[5] ? GM_STROBED : GM_BASIC);
    c.a_in      = w[4];
    c.cu_in     = w[3];
    c.b_strobed = w[2];
    c.b_in      = w[1];
    c.cl_in     = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] apply_bitop(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    r = cur;
    r[w[3:1]] = w[0];
    return r;
  endfunction

  function automatic logic a_takes_input(input cfg_t c);
    return (c.a_mode == GM_BIDIR) || ((c.a_mode == GM_STROBED) && c.a_in);
  endfunction

  function automatic logic a_gives_output(input cfg_t c);
    return (c.a_mode == GM_BIDIR) || ((c.a_mode == GM_STROBED) && !c.a_in);
  endfunction

  function automatic crole_t c_roles(input cfg_t c);
    crole_t r;
    r.drv   = '0;
    r.sense = '0;
    if (c.b_strobed) begin
      r.drv[C_IRQ_B]  = 1'b1;
      r.drv[C_FLG_B]  = 1'b1;
      r.sense[C_HS_B] = 1'b1;
    end
    if (c.a_mode != GM_BASIC) r.drv[C_IRQ_A] = 1'b1;
    if (a_takes_input(c)) begin
      r.sense[C_STB_A] = 1'b1;
      r.drv[C_IBF_A]   = 1'b1;
    end
    if (a_gives_output(c)) begin
      r.sense[C_ACK_A] = 1'b1;
      r.drv[C_OBF_A]   = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] nibble_oe(input logic hi_in, input logic lo_in);
    return {{(DATA_W/2){~hi_in}}, {(DATA_W/2){~lo_in}}};
  endfunction

  function automatic logic irq_calc(input logic in_en, input logic ibf, input logic en_in,
                                    input logic out_en, input logic done, input logic en_out);
    return (in_en & ibf & en_in) | (out_en & done & en_out);
  endfunction
endpackage

// File: rtl/pario_host_if.sv
module pario_host_if (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_evt,
  output logic rd_evt
);
  logic wr_act, rd_act, wr_prev, rd_prev;

  assign wr_act = ~sel_n & ~wr_n;
  assign rd_act = ~sel_n & ~rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
    end
  end

  assign wr_evt = wr_act & ~wr_prev;
  assign rd_evt = rd_act & ~rd_prev;
endmodule

// File: rtl/pario_cfg_regs.sv
module pario_cfg_regs import pario_pkg::*; #(
  parameter logic [DATA_W-1:0] RESET_CTRL = 8'h9B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] a_latch,
  output logic [DATA_W-1:0] b_latch,
  output logic [DATA_W-1:0] c_latch,
  output logic              mode_wr
);
  assign mode_wr = wr_evt && (addr == LOC_CTL) && wdata[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= decode_mode(RESET_CTRL);
      a_latch <= '0;
      b_latch <= '0;
      c_latch <= '0;
    end else if (wr_evt) begin
      case (addr)
        LOC_A: a_latch <= wdata;
        LOC_B: b_latch <= wdata;
        LOC_C: c_latch <= wdata;
        default: begin
          if (wdata[DATA_W-1]) begin
            cfg     <= decode_mode(wdata);
            a_latch <= '0;
            b_latch <= '0;
            c_latch <= '0;
          end else begin
            c_latch <= apply_bitop(c_latch, wdata);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pario_hs_chan.sv
module pario_hs_chan import pario_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_en,
  input  logic              out_en,
  input  logic              stb_n,
  input  logic              ack_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              rd_evt,
  input  logic              wr_evt,
  output logic [DATA_W-1:0] in_data,
  output logic              ibf,
  output logic              full,
  output logic              done,
  output logic              stb_fall,
  output logic              ack_fall
);
  logic stb_prev, ack_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev <= 1'b1;
      ack_prev <= 1'b1;
    end else begin
      stb_prev <= stb_n;
      ack_prev <= ack_n;
    end
  end

  assign stb_fall = in_en & stb_prev & ~stb_n;
  assign ack_fall = out_en & ack_prev & ~ack_n;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      in_data <= '0;
      ibf     <= 1'b0;
      full    <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (stb_fall) begin
        in_data <= pin_data;
        ibf     <= 1'b1;
      end else if (rd_evt) begin
        ibf <= 1'b0;
      end
      if (wr_evt) begin
        full <= 1'b1;
        done <= 1'b0;
      end else if (ack_fall) begin
        full <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pario_portc.sv
module pario_portc import pario_pkg::*; (
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] c_latch,
  input  logic [DATA_W-1:0] c_pins,
  input  logic [DATA_W-1:0] hs_val,
  output logic [DATA_W-1:0] c_out,
  output logic [DATA_W-1:0] c_oe,
  output logic [DATA_W-1:0] c_read
);
  crole_t            roles;
  logic [DATA_W-1:0] io_out, take_latch, take_pin;

  always_comb begin
    roles      = c_roles(cfg);
    io_out     = nibble_oe(cfg.cu_in, cfg.cl_in);
    c_oe       = roles.drv | (~roles.drv & ~roles.sense & io_out);
    c_out      = (roles.drv & hs_val) | (~roles.drv & c_latch);
    take_latch = ~roles.drv & (roles.sense | io_out);
    take_pin   = ~roles.drv & ~roles.sense & ~io_out;
    c_read     = (roles.drv & hs_val) | (take_latch & c_latch) | (take_pin & c_pins);
  end
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl import pario_pkg::*; #(
  parameter logic [DATA_W-1:0] RESET_CTRL = 8'h9B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  input  logic [DATA_W-1:0] line_a_in,
  output logic [DATA_W-1:0] line_a_out,
  output logic [DATA_W-1:0] line_a_oe,
  input  logic [DATA_W-1:0] line_b_in,
  output logic [DATA_W-1:0] line_b_out,
  output logic [DATA_W-1:0] line_b_oe,
  input  logic [DATA_W-1:0] line_c_in,
  output logic [DATA_W-1:0] line_c_out,
  output logic [DATA_W-1:0] line_c_oe
);
  logic              wr_evt, rd_evt, mode_wr;
  cfg_t              cfg;
  logic [DATA_W-1:0] a_latch, b_latch, c_latch;
  logic [NCH-1:0]    ch_in_en, ch_out_en, ch_stb_n, ch_ack_n, ch_rd, ch_wr;
  logic [NCH-1:0]    ch_ibf, ch_full, ch_done, ch_stb_fall, ch_ack_fall;
  logic [NCH-1:0][DATA_W-1:0] ch_pin, ch_din;
  logic [DATA_W-1:0] c_hs_val, c_read, a_read, b_read;
  logic              irq_a, irq_b;

  pario_host_if u_host (
    .clk(clk), .rst(rst), .sel_n(host_sel_n), .rd_n(host_rd_n), .wr_n(host_wr_n),
    .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  pario_cfg_regs #(.RESET_CTRL(RESET_CTRL)) u_regs (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .addr(host_addr), .wdata(host_wdata),
    .cfg(cfg), .a_latch(a_latch), .b_latch(b_latch), .c_latch(c_latch), .mode_wr(mode_wr)
  );

  // channel wiring per group
  always_comb begin
    ch_in_en[CH_A]  = a_takes_input(cfg);
    ch_out_en[CH_A] = a_gives_output(cfg);
    ch_stb_n[CH_A]  = line_c_in[C_STB_A];
    ch_ack_n[CH_A]  = line_c_in[C_ACK_A];
    ch_pin[CH_A]    = line_a_in;
    ch_rd[CH_A]     = rd_evt && (host_addr == LOC_A) && ch_in_en[CH_A];
    ch_wr[CH_A]     = wr_evt && (host_addr == LOC_A) && ch_out_en[CH_A];
    ch_in_en[CH_B]  = cfg.b_strobed & cfg.b_in;
    ch_out_en[CH_B] = cfg.b_strobed & ~cfg.b_in;
    ch_stb_n[CH_B]  = line_c_in[C_HS_B];
    ch_ack_n[CH_B]  = line_c_in[C_HS_B];
    ch_pin[CH_B]    = line_b_in;
    ch_rd[CH_B]     = rd_evt && (host_addr == LOC_B) && ch_in_en[CH_B];
    ch_wr[CH_B]     = wr_evt && (host_addr == LOC_B) && ch_out_en[CH_B];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pario_hs_chan u_chan (
      .clk(clk), .rst(rst), .clr(mode_wr),
      .in_en(ch_in_en[g]), .out_en(ch_out_en[g]),
      .stb_n(ch_stb_n[g]), .ack_n(ch_ack_n[g]), .pin_data(ch_pin[g]),
      .rd_evt(ch_rd[g]), .wr_evt(ch_wr[g]),
      .in_data(ch_din[g]), .ibf(ch_ibf[g]), .full(ch_full[g]), .done(ch_done[g]),
      .stb_fall(ch_stb_fall[g]), .ack_fall(ch_ack_fall[g])
    );
  end

  assign irq_a = irq_calc(ch_in_en[CH_A], ch_ibf[CH_A], c_latch[C_STB_A],
                          ch_out_en[CH_A], ch_done[CH_A], c_latch[C_ACK_A]);
  assign irq_b = irq_calc(ch_in_en[CH_B], ch_ibf[CH_B], c_latch[C_HS_B],
                          ch_out_en[CH_B], ch_done[CH_B], c_latch[C_HS_B]);

  always_comb begin
    c_hs_val          = '0;
    c_hs_val[C_IRQ_B] = irq_b;
    c_hs_val[C_FLG_B] = ch_in_en[CH_B] ? ch_ibf[CH_B] : ~ch_full[CH_B];
    c_hs_val[C_IRQ_A] = irq_a;
    c_hs_val[C_IBF_A] = ch_ibf[CH_A];
    c_hs_val[C_OBF_A] = ~ch_full[CH_A];
  end

  pario_portc u_portc (
    .cfg(cfg), .c_latch(c_latch), .c_pins(line_c_in), .hs_val(c_hs_val),
    .c_out(line_c_out), .c_oe(line_c_oe), .c_read(c_read)
  );

  // port A: bidirectional drive gated by acknowledge line
  assign line_a_out = a_latch;
  assign line_a_oe  = (cfg.a_mode == GM_BIDIR) ? {DATA_W{~line_c_in[C_ACK_A]}}
                                                : {DATA_W{~cfg.a_in}};
  assign a_read     = (cfg.a_mode == GM_BASIC) ? (cfg.a_in ? line_a_in : a_latch)
                                                : (ch_in_en[CH_A] ? ch_din[CH_A] : a_latch);

  assign line_b_out = b_latch;
  assign line_b_oe  = {DATA_W{~cfg.b_in}};
  assign b_read     = cfg.b_in ? (cfg.b_strobed ? ch_din[CH_B] : line_b_in) : b_latch;

  always_comb begin
    case (host_addr)
      LOC_A:   host_rdata = a_read;
      LOC_B:   host_rdata = b_read;
      LOC_C:   host_rdata = c_read;
      default: host_rdata = '0;
    endcase
  end
  assign host_rdata_oe = ~host_sel_n & ~host_rd_n;
endmodule

// File: rtl/pario_ctrl_chk.sv
module pario_ctrl_chk import pario_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              host_sel_n,
  input logic [DATA_W-1:0] line_c_in,
  input logic [DATA_W-1:0] line_a_out,
  input logic [DATA_W-1:0] line_a_oe,
  input logic [DATA_W-1:0] line_b_out,
  input logic [DATA_W-1:0] line_b_oe,
  input logic [DATA_W-1:0] line_c_out,
  input logic [DATA_W-1:0] line_c_oe,
  input cfg_t              cfg,
  input logic              mode_wr,
  input logic [NCH-1:0]    ch_ibf,
  input logic [NCH-1:0]    ch_done,
  input logic [NCH-1:0]    ch_full,
  input logic [NCH-1:0]    ch_stb_fall,
  input logic [NCH-1:0]    ch_ack_fall,
  input logic [NCH-1:0]    ch_wr
);
  // R1
  reset_inputs_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_a_oe == '0 && line_b_oe == '0 && line_c_oe == '0));

  // R2
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    host_sel_n |=> ($stable(line_a_out) && $stable(line_b_out)));

  // R3
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (line_a_out == '0 && line_b_out == '0 && ch_ibf == '0 && ch_full == '0));

  // R6
  ibf_a_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_ibf[CH_A]) |-> $past(ch_stb_fall[CH_A]));

  // R6
  ibf_b_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_ibf[CH_B]) |-> $past(ch_stb_fall[CH_B]));

  // R7
  irq_b_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.b_strobed && !ch_ibf[CH_B] && !ch_done[CH_B]) |-> !line_c_out[C_IRQ_B]);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_ack_fall[CH_A] && !ch_wr[CH_A]) |=> !ch_full[CH_A]);

  // R9
  bidir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.a_mode == GM_BIDIR && line_c_in[C_ACK_A]) |-> (line_a_oe == '0));
endmodule

bind pario_ctrl pario_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .line_c_in(line_c_in),
  .line_a_out(line_a_out), .line_a_oe(line_a_oe),
  .line_b_out(line_b_out), .line_b_oe(line_b_oe),
  .line_c_out(line_c_out), .line_c_oe(line_c_oe),
  .cfg(cfg), .mode_wr(mode_wr), .ch_ibf(ch_ibf), .ch_done(ch_done), .ch_full(ch_full),
  .ch_stb_fall(ch_stb_fall), .ch_ack_fall(ch_ack_fall), .ch_wr(ch_wr)
);

// File: tb/tb_pario_ctrl.sv
module tb_pario_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [7:0] a_in = 8'h00, b_in = 8'h00, c_in = 8'hFF;
  logic [7:0] a_out, a_oe, b_out, b_oe, c_out, c_oe;
  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pario_ctrl dut (
    .clk(clk), .rst(rst), .host_sel_n(sel_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .host_rdata_oe(rdata_oe),
    .line_a_in(a_in), .line_a_out(a_out), .line_a_oe(a_oe),
    .line_b_in(b_in), .line_b_out(b_out), .line_b_oe(b_oe),
    .line_c_in(c_in), .line_c_out(c_out), .line_c_oe(c_oe)
  );

  // basic-mode vectors: {control word, write data, pin data}
  localparam logic [23:0] VEC [4] = '{
    {8'h80, 8'hA5, 8'h3C},
    {8'h9B, 8'hA5, 8'h3C},
    {8'h91, 8'h5A, 8'hC3},
    {8'h8A, 8'h0F, 8'h96}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    sel_n = ~sel; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    d = rdata; oe = rdata_oe;
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse_c(input int bitn);
    @(negedge clk);
    c_in[bitn] = 1'b0;
    @(negedge clk);
    c_in[bitn] = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] port_oe(input logic is_in);
    return is_in ? 8'h00 : 8'hFF;
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    a_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 a_oe", a_oe, 8'h00);
    chk("R1 b_oe", b_oe, 8'h00);
    chk("R1 c_oe", c_oe, 8'h00);
    chk("R1 a_out", a_out, 8'h00);
    chk("R11 idle oe", {7'd0, rdata_oe}, 8'h00);
    rd(2'd0, d, oe);
    chk("R1 read A pins", d, 8'h3C);
    chk("R11 read oe", {7'd0, oe}, 8'h01);
    rd(2'd2, d, oe);
    chk("R1 read C pins", d, 8'hFF);
    rd(2'd3, d, oe);
    chk("R2 ctl read", d, 8'h00);

    // R4 table walk of basic-mode direction mixes
    for (int i = 0; i < 4; i++) begin
      logic [7:0] cw, wv, pv, coe;
      cw = VEC[i][23:16]; wv = VEC[i][15:8]; pv = VEC[i][7:0];
      wr(2'd3, cw);
      wr(2'd0, wv); wr(2'd1, wv); wr(2'd2, wv);
      a_in = pv; b_in = pv; c_in = pv;
      coe = {port_oe(cw[3])[7:4], port_oe(cw[0])[3:0]};
      chk("R4 a_oe", a_oe, port_oe(cw[4]));
      chk("R4 b_oe", b_oe, port_oe(cw[1]));
      chk("R4 c_oe", c_oe, coe);
      chk("R4 a_out", a_out, wv);
      chk("R4 c_out", c_out, wv);
      rd(2'd0, d, oe);
      chk("R4 read A", d, (wv & port_oe(cw[4])) | (pv & ~port_oe(cw[4])));
      rd(2'd1, d, oe);
      chk("R4 read B", d, (wv & port_oe(cw[1])) | (pv & ~port_oe(cw[1])));
      rd(2'd2, d, oe);
      chk("R10 read C basic", d, (wv & coe) | (pv & ~coe));
    end
    c_in = 8'hFF;

    // R2 select gating, R3 mode write clears latches
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h12);
    wr(2'd0, 8'hEE, 1'b0);
    chk("R2 unselected write", a_out, 8'h12);
    wr(2'd3, 8'h80);
    chk("R3 latch cleared", a_out, 8'h00);

    // R5 single-bit operations
    wr(2'd3, 8'h0B);
    chk("R5 set bit5", c_out, 8'h20);
    wr(2'd3, 8'h01);
    chk("R5 set bit0", c_out, 8'h21);
    wr(2'd3, 8'h0A);
    chk("R5 clear bit5", c_out, 8'h01);

    // R6/R7 strobed input on group A
    wr(2'd3, 8'hB8);
    chk("R6 c_oe", c_oe, 8'h2F);
    chk("R6 ibf idle", {7'd0, c_out[5]}, 8'h00);
    a_in = 8'h5A;
    pulse_c(4);
    a_in = 8'h00;
    chk("R6 ibf set", {7'd0, c_out[5]}, 8'h01);
    chk("R7 irq masked", {7'd0, c_out[3]}, 8'h00);
    rd(2'd2, d, oe);
    chk("R10 read C strobed", d, 8'hE0);
    wr(2'd3, 8'h09);
    chk("R7 irq enabled", {7'd0, c_out[3]}, 8'h01);
    rd(2'd2, d, oe);
    chk("R10 read C enable", d, 8'hF8);
    rd(2'd0, d, oe);
    chk("R6 latched data", d, 8'h5A);
    chk("R6 ibf cleared", {7'd0, c_out[5]}, 8'h00);
    chk("R7 irq cleared", {7'd0, c_out[3]}, 8'h00);

    // R8 strobed output on group B
    wr(2'd3, 8'h9C);
    chk("R8 c_oe", c_oe, 8'h0B);
    chk("R8 obf idle high", {7'd0, c_out[1]}, 8'h01);
    wr(2'd3, 8'h05);
    chk("R8 irq idle", {7'd0, c_out[0]}, 8'h00);
    wr(2'd1, 8'hC3);
    chk("R8 b_out", b_out, 8'hC3);
    chk("R8 b_oe", b_oe, 8'hFF);
    chk("R8 obf low", {7'd0, c_out[1]}, 8'h00);
    pulse_c(2);
    chk("R8 obf released", {7'd0, c_out[1]}, 8'h01);
    chk("R8 irq raised", {7'd0, c_out[0]}, 8'h01);
    rd(2'd2, d, oe);
    chk("R10 read C output", d, 8'hF7);
    wr(2'd1, 8'h11);
    chk("R8 irq cleared by write", {7'd0, c_out[0]}, 8'h00);
    chk("R8 obf low again", {7'd0, c_out[1]}, 8'h00);

    // R9 bidirectional port A
    wr(2'd3, 8'hC3);
    chk("R9 c_oe", c_oe, 8'hA8);
    wr(2'd0, 8'h77);
    chk("R9 obf low", {7'd0, c_out[7]}, 8'h00);
    chk("R9 no drive", a_oe, 8'h00);
    @(negedge clk);
    c_in[6] = 1'b0;
    #1;
    chk("R9 drive on ack", a_oe, 8'hFF);
    chk("R9 data on ack", a_out, 8'h77);
    @(negedge clk);
    c_in[6] = 1'b1;
    @(negedge clk);
    chk("R9 obf released", {7'd0, c_out[7]}, 8'h01);
    chk("R9 drive off", a_oe, 8'h00);
    wr(2'd3, 8'h0D);
    chk("R9 out irq", {7'd0, c_out[3]}, 8'h01);
    a_in = 8'h3C;
    pulse_c(4);
    chk("R9 ibf set", {7'd0, c_out[5]}, 8'h01);
    rd(2'd0, d, oe);
    chk("R9 input data", d, 8'h3C);
    chk("R9 ibf cleared", {7'd0, c_out[5]}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R9 irq cleared", {7'd0, c_out[3]}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule